// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block turns single-word requests from an on-chip host into timed cycles on an external 8-bit parallel bus. The host loads a configuration word, an address and a data byte. Writing the data byte launches a bus write. A separate read command launches a bus read, and the captured byte replaces the data byte when the block goes idle. During a cycle the block drives a chip select, the address lines and the data lines. It also drives read/write strobes in one of two styles. All phase lengths are counted in clocks of the single internal clock.

Each cycle runs through five phases. The setup phase lasts 1 to 4 clocks. The strobe phase lasts 1 to 15 clocks. The hold phase lasts 0 to 3 clocks. A one-clock completion phase follows. In the completion phase the address may be stepped up or down and an interrupt pulse may be raised. Address stepping acts only on address bits 10 down to 2, with bit 14 acting as their carry/borrow bit. Bit 14 can instead serve as a second chip-select line, in which case it is left out of stepping.

Top module: `parbus_master`

## Requirements
- R1: After a synchronous active-low reset the configuration word, address and data byte are all 0. `busy`, `irq`, `bus_cs`, every strobe and `bus_doe` are low.
- R2: Bus cycles start only when configuration bits [1:0] select a master style (2'b10 or 2'b11). A `data_we` pulse starts a write and a `rd_go` pulse starts a read; if both arrive together, the write wins. `busy` rises on the clock after the start and stays high for setup + strobe + hold + 1 clocks. With bits [1:0] = 2'b00 or 2'b01, starts are ignored and the data byte keeps its value.
- R3: Setup wait field bits [3:2] = n gives n+1 clocks with `bus_cs` high and no strobe before the strobe.
- R4: Strobe wait field bits [7:4] = m (m ≥ 1) gives a strobe that is active for m clocks.
- R5: End wait field bits [9:8] = e gives e clocks after the strobe with `bus_cs` still high. One further clock follows with `busy` high and `bus_cs` low.
- R6: When bits [7:4] = 0, bits [3:2] and [9:8] are ignored. The cycle then has a 1-clock setup and a 1-clock strobe. The hold is 1 clock for a write and 0 clocks for a read.
- R7: Style 2'b10 pulses `bus_rd` for reads and `bus_wr` for writes, and keeps `bus_en` and `bus_dir` low. Style 2'b11 pulses `bus_en`, holds `bus_dir` high for all `bus_cs` clocks of a read (low for a write), and keeps `bus_rd` and `bus_wr` low.
- R8: `bus_doe` is high exactly while `bus_cs` is high during a write, and `bus_dout` then equals the byte written. A read captures `bus_din` on the last strobe clock into `data_q`.
- R9: Step field bits [11:10]: 00 = no change, 01 = +1, 10 = −1, 11 = no change. The step is applied once per cycle and is visible on `addr_q` when `busy` falls.
- R10: Stepping acts on the 10-bit value {addr[14], addr[10:2]} and wraps modulo 1024. When bit [14] of the configuration is set, only addr[10:2] steps (modulo 512), addr[14] is kept, and `bus_addr[14]` carries the chip select. Other address bits never change.
- R11: Interrupt field bits [13:12] = 01 gives exactly one `irq` clock per cycle, in the completion clock. The values 00, 10 and 11 give no interrupt.
- R12: While `busy` is high, starts, configuration writes and address writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one wait unit |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load configuration word |
| cfg_wdata | input | 15 | Configuration word |
| addr_we | input | 1 | Load address register |
| addr_wdata | input | 16 | Address value |
| data_we | input | 1 | Load data byte and start a write |
| data_wdata | input | 8 | Byte to write |
| rd_go | input | 1 | Start a read |
| busy | output | 1 | Bus cycle in progress |
| irq | output | 1 | One-clock completion interrupt |
| data_q | output | 8 | Data byte (written value or read result) |
| addr_q | output | 16 | Current address register |
| bus_cs | output | 1 | Chip select |
| bus_rd | output | 1 | Read strobe (split style) |
| bus_wr | output | 1 | Write strobe (split style) |
| bus_en | output | 1 | Enable strobe (direction style) |
| bus_dir | output | 1 | Direction, high for read (direction style) |
| bus_addr | output | 16 | Address lines |
| bus_dout | output | 8 | Data driven on the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Data read from the bus |

## Verification
A start presented before a clock edge is accepted at that edge. From the next clock the bus shows setup, strobe, hold and completion clocks back to back. The read byte and the stepped address are due on `data_q` and `addr_q` in the first clock where `busy` is low. The bench drives inputs and samples outputs on the falling edge, and counts each phase one clock at a time until `busy` drops. It reloads `bus_din` every clock so that only the byte present on the final strobe clock can match. The sweep covers both styles and every setup and end wait value. It uses several strobe lengths including 0 and 15, and it also rotates step, interrupt and chip-select settings.

// File: rtl/parbus_pkg.sv
// Shared types for the parallel bus master.
// Assumes one internal clock; all wait fields count its periods.
package parbus_pkg;

    localparam int MID_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    // Configuration word, MSB first: bit14 cs-on-a14, [13:12] irq, [11:10] step,
    // [9:8] end wait, [7:4] strobe wait, [3:2] setup wait, [1:0] style.
    typedef struct packed {
        logic             cs_on_a14;
        logic [1:0]       irq_sel;
        logic [1:0]       step_sel;
        logic [1:0]       end_ws;
        logic [MID_W-1:0] mid_ws;
        logic [1:0]       setup_ws;
        logic [1:0]       style;
    } cfg_t;

    localparam logic [1:0] STYLE_SPLIT  = 2'b10;
    localparam logic [1:0] STEP_UP      = 2'b01;
    localparam logic [1:0] STEP_DOWN    = 2'b10;
    localparam logic [1:0] IRQ_PER_CYC  = 2'b01;

endpackage

// File: rtl/parbus_timing.sv
// Turns the three wait fields into phase lengths in clocks.
// Assumes the fields are stable while a cycle runs (the top locks them).
module parbus_timing
    import parbus_pkg::*;
(
    input  logic [1:0]       setup_ws,
    input  logic [MID_W-1:0] mid_ws,
    input  logic [1:0]       end_ws,
    input  logic             is_rd,
    output logic [2:0]       setup_len,
    output logic [MID_W-1:0] strobe_len,
    output logic [1:0]       hold_len
);

    // Zero strobe wait overrides the other two fields.
    always_comb begin
        if (mid_ws == '0) begin
            setup_len  = 3'd1;
            strobe_len = MID_W'(1);
            hold_len   = is_rd ? 2'd0 : 2'd1;
        end else begin
            setup_len  = {1'b0, setup_ws} + 3'd1;
            strobe_len = mid_ws;
            hold_len   = end_ws;
        end
    end

endmodule

// File: rtl/parbus_seq.sv
// Phase sequencer: IDLE -> SETUP -> STROBE -> HOLD (skipped if 0) -> DONE.
// One down-counter is reloaded from the phase lengths on each transition.
// Assumes start_wr/start_rd are only raised when the top allows a start.
module parbus_seq
    import parbus_pkg::*;
#(
    parameter int CNT_W = MID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             start_rd,
    input  logic [2:0]       setup_len,
    input  logic [CNT_W-1:0] strobe_len,
    input  logic [1:0]       hold_len,
    output phase_t           phase,
    output logic             cyc_rd,
    output logic             last_strobe
);

    logic [CNT_W-1:0] cnt;

    // Advance the phase and reload or count down the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            cyc_rd <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start_wr || start_rd) begin
                        phase  <= PH_SETUP;
                        cnt    <= CNT_W'(setup_len) - CNT_W'(1);
                        cyc_rd <= !start_wr;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= strobe_len - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        if (hold_len == 2'd0) begin
                            phase <= PH_DONE;
                        end else begin
                            phase <= PH_HOLD;
                            cnt   <= CNT_W'(hold_len) - CNT_W'(1);
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_DONE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Flag the final strobe clock for read capture.
    always_comb last_strobe = (phase == PH_STROBE) && (cnt == '0);

    AST_START_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && (start_wr || start_rd)) |=> (phase == PH_SETUP)); // R2
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE)); // R5
    AST_HOLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> ($past(phase) == PH_STROBE || $past(phase) == PH_HOLD)); // R5

endmodule

// File: rtl/parbus_addr.sv
// Address register with partial auto-step.
// Steps the field {a[CS_BIT], a[STEP_HI:STEP_LO]}; when cs_on is set only the low
// part steps and a[CS_BIT] is kept. Assumes CS_BIT > STEP_HI and STEP_LO >= 1.
module parbus_addr
    import parbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int STEP_LO = 2,
    parameter int STEP_HI = 10,
    parameter int CS_BIT  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          step_now,
    input  logic [1:0]    step_sel,
    input  logic          cs_on,
    output logic [AW-1:0] addr_q
);

    localparam int FW = STEP_HI - STEP_LO + 1;
    localparam int EW = FW + 1;

    logic [EW-1:0] ext, ext_next;
    logic [AW-1:0] stepped;

    // Compute the stepped address from the current one.
    always_comb begin
        ext = {addr_q[CS_BIT], addr_q[STEP_HI:STEP_LO]};
        case (step_sel)
            STEP_UP:   ext_next = ext + EW'(1);
            STEP_DOWN: ext_next = ext - EW'(1);
            default:   ext_next = ext;
        endcase
        stepped = addr_q;
        stepped[STEP_HI:STEP_LO] = ext_next[FW-1:0];
        if (!cs_on) stepped[CS_BIT] = ext_next[FW];
    end

    // Hold the address; a step has priority over a host load.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (step_now) addr_q <= stepped;
        else if (addr_we)  addr_q <= addr_wdata;
    end

    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        step_now |=> (addr_q[STEP_LO-1:0] == $past(addr_q[STEP_LO-1:0]))); // R10
    AST_CS_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now && cs_on) |=> (addr_q[CS_BIT] == $past(addr_q[CS_BIT]))); // R10

endmodule

// File: rtl/parbus_master.sv
// Parallel bus master: host register side plus timed external bus cycles.
// Configuration, address and data are locked while busy. Bus outputs are
// decoded from the registered phase. Assumes bus_din is stable on the last strobe clock.
module parbus_master
    import parbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int STEP_LO = 2,
    parameter int STEP_HI = 10,
    parameter int CS_BIT  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [14:0]   cfg_wdata,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    input  logic          rd_go,
    output logic          busy,
    output logic          irq,
    output logic [DW-1:0] data_q,
    output logic [AW-1:0] addr_q,
    output logic          bus_cs,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_en,
    output logic          bus_dir,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din
);

    cfg_t             cfg;
    phase_t           phase;
    logic             idle, master, start_wr, start_rd;
    logic             cyc_rd, last_strobe, in_cyc, strobe, split;
    logic [2:0]       setup_len;
    logic [MID_W-1:0] strobe_len;
    logic [1:0]       hold_len;

    // Qualify host starts: idle and a master style selected.
    always_comb begin
        idle     = (phase == PH_IDLE);
        master   = cfg.style[1];
        start_wr = idle && master && data_we;
        start_rd = idle && master && rd_go && !data_we;
    end

    // Configuration register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)             cfg <= '0;
        else if (cfg_we && idle) cfg <= cfg_t'(cfg_wdata);
    end

    // Data register: loaded by a write start, replaced by read capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (start_wr)               data_q <= data_wdata;
        else if (last_strobe && cyc_rd)  data_q <= bus_din;
    end

    parbus_timing u_timing (
        .setup_ws   (cfg.setup_ws),
        .mid_ws     (cfg.mid_ws),
        .end_ws     (cfg.end_ws),
        .is_rd      (cyc_rd),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len)
    );

    parbus_seq #(.CNT_W(MID_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .start_rd    (start_rd),
        .setup_len   (setup_len),
        .strobe_len  (strobe_len),
        .hold_len    (hold_len),
        .phase       (phase),
        .cyc_rd      (cyc_rd),
        .last_strobe (last_strobe)
    );

    parbus_addr #(
        .AW(AW), .STEP_LO(STEP_LO), .STEP_HI(STEP_HI), .CS_BIT(CS_BIT)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (addr_we && idle),
        .addr_wdata (addr_wdata),
        .step_now   (phase == PH_DONE),
        .step_sel   (cfg.step_sel),
        .cs_on      (cfg.cs_on_a14),
        .addr_q     (addr_q)
    );

    // Decode bus pins, busy and interrupt from the phase.
    always_comb begin
        in_cyc   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe   = (phase == PH_STROBE);
        split    = (cfg.style == STYLE_SPLIT);
        busy     = !idle;
        bus_cs   = in_cyc;
        bus_rd   = split && strobe && cyc_rd;
        bus_wr   = split && strobe && !cyc_rd;
        bus_en   = !split && strobe;
        bus_dir  = !split && in_cyc && cyc_rd;
        bus_doe  = in_cyc && !cyc_rd;
        bus_dout = data_q;
        irq      = (phase == PH_DONE) && (cfg.irq_sel == IRQ_PER_CYC);
        bus_addr = addr_q;
        if (cfg.cs_on_a14) bus_addr[CS_BIT] = in_cyc;
    end

    AST_SPLIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R7
    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr || bus_en) |-> bus_cs); // R3
    AST_DOE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (bus_cs && !bus_rd && !bus_dir)); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R11
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg)); // R12
    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_DONE) |=> $stable(addr_q)); // R12

endmodule

// File: tb/tb_parbus_master.sv
// Sweep bench: both styles, all setup/end waits, several strobe waits, both directions.
module tb_parbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, addr_we = 1'b0, data_we = 1'b0, rd_go = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic [15:0] addr_wdata = '0;
    logic [7:0]  data_wdata = '0;
    logic [7:0]  bus_din = '0;
    logic        busy, irq, bus_cs, bus_rd, bus_wr, bus_en, bus_dir, bus_doe;
    logic [7:0]  data_q, bus_dout;
    logic [15:0] addr_q, bus_addr;

    always #10 clk = ~clk;

    parbus_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .data_we(data_we),
        .data_wdata(data_wdata), .rd_go(rd_go), .busy(busy), .irq(irq),
        .data_q(data_q), .addr_q(addr_q), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_en(bus_en), .bus_dir(bus_dir), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_step(logic [15:0] a, logic [1:0] sel, bit cs);
        int d; int lo; int f; logic [15:0] r;
        d = (sel == 2'b01) ? 1 : (sel == 2'b10) ? -1 : 0;
        r = a;
        if (cs) begin
            lo = int'(a[10:2]);
            lo = (lo + d + 512) % 512;
            r[10:2] = 9'(lo);
        end else begin
            f = int'({a[14], a[10:2]});
            f = (f + d + 1024) % 1024;
            r[10:2] = 9'(f);
            r[14] = (f >= 512);
        end
        return r;
    endfunction

    function automatic logic [14:0] mk_cfg(bit cs, logic [1:0] iq, logic [1:0] st,
            logic [1:0] we, logic [3:0] wm, logic [1:0] ws, logic [1:0] sty);
        return {cs, iq, st, we, wm, ws, sty};
    endfunction

    task automatic wr_cfg(input logic [14:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wr_addr(input logic [15:0] v);
        @(negedge clk); addr_we = 1'b1; addr_wdata = v;
        @(negedge clk); addr_we = 1'b0;
    endtask

    int c_setup, c_strobe, c_hold, c_done, c_irq, c_badpin, c_badaddr;
    logic [7:0] exp_rd;

    // One bus cycle; counts phases clock by clock at the falling edge.
    task automatic run_cycle(input bit rd, input logic [7:0] wv, input logic [1:0] sty,
                             input bit cs_on, input bit poke);
        bit st; bit seen;
        c_setup = 0; c_strobe = 0; c_hold = 0; c_done = 0; c_irq = 0;
        c_badpin = 0; c_badaddr = 0; seen = 0;
        @(negedge clk);
        if (rd) rd_go = 1'b1;
        else begin data_we = 1'b1; data_wdata = wv; end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            rd_go = 1'b0; data_we = 1'b0; cfg_we = 1'b0; addr_we = 1'b0;
            if (!busy) break;
            if (poke && k == 1) begin
                data_we = 1'b1; data_wdata = ~wv; rd_go = 1'b1;
                cfg_we = 1'b1; cfg_wdata = '0; addr_we = 1'b1; addr_wdata = 16'h1234;
            end
            st = bus_rd || bus_wr || bus_en;
            if (st) begin c_strobe++; seen = 1; end
            else if (bus_cs && !seen) c_setup++;
            else if (bus_cs) c_hold++;
            else c_done++;
            if (irq) c_irq++;
            if (sty == 2'b10) begin
                if (bus_en || bus_dir || bus_rd != (st && rd) || bus_wr != (st && !rd)) c_badpin++;
            end else begin
                if (bus_rd || bus_wr || bus_dir != (bus_cs && rd)) c_badpin++;
            end
            if (bus_doe != (bus_cs && !rd)) c_badpin++;
            if (bus_doe && bus_dout != wv) c_badpin++;
            if (cs_on) begin
                if (bus_addr[14] != bus_cs || (bus_addr & 16'hBFFF) != (addr_q & 16'hBFFF)) c_badaddr++;
            end else if (bus_addr != addr_q) c_badaddr++;
            bus_din = 8'(k * 37 + int'(wv));
            if (st) exp_rd = bus_din;
        end
    endtask

    int wm_list[6] = '{0, 1, 2, 3, 7, 15};
    logic [15:0] exp_addr;

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int idx; int es, em, eh; bit cs; logic [1:0] iq, stp; logic [7:0] wv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && irq == 0 && bus_cs == 0, "R1 idle controls", int'({busy, irq, bus_cs}), 0);
        chk(bus_rd == 0 && bus_wr == 0 && bus_en == 0 && bus_doe == 0, "R1 strobes low",
            int'({bus_rd, bus_wr, bus_en, bus_doe}), 0);
        chk(data_q == 0 && addr_q == 0, "R1 data/addr zero", int'({data_q, addr_q}), 0);

        // R2 starts ignored in non-master style (config 0 after reset)
        @(negedge clk); data_we = 1'b1; data_wdata = 8'h77;
        @(negedge clk); data_we = 1'b0; rd_go = 1'b1;
        @(negedge clk); rd_go = 1'b0;
        chk(busy == 0, "R2 non-master start ignored", int'(busy), 0);
        chk(data_q == 0, "R2 non-master data kept", int'(data_q), 0);
        wr_cfg(mk_cfg(0, 2'b00, 2'b00, 2'b00, 4'd1, 2'b00, 2'b01));
        @(negedge clk); data_we = 1'b1; data_wdata = 8'h55;
        @(negedge clk); data_we = 1'b0;
        chk(busy == 0 && data_q == 0, "R2 style01 start ignored", int'(busy), 0);

        // Main sweep: R3 R4 R5 R6 R7 R8 R9 R10 R11
        wr_addr(16'h87F8);
        exp_addr = 16'h87F8;
        idx = 0;
        for (int sty = 2; sty < 4; sty++)
        for (int ws = 0; ws < 4; ws++)
        for (int wi = 0; wi < 6; wi++)
        for (int we = 0; we < 4; we++)
        for (int rd = 0; rd < 2; rd++) begin
            cs  = idx[2];
            iq  = 2'(idx + ws);
            stp = 2'(idx / 3);
            wv  = 8'(idx * 29 + 3);
            wr_cfg(mk_cfg(cs, iq, stp, 2'(we), 4'(wm_list[wi]), 2'(ws), 2'(sty)));
            run_cycle(rd[0], wv, 2'(sty), cs, 1'b0);
            if (wm_list[wi] == 0) begin es = 1; em = 1; eh = (rd != 0) ? 0 : 1; end
            else begin es = ws + 1; em = wm_list[wi]; eh = we; end
            chk(c_setup == es, (wm_list[wi] == 0) ? "R6 setup forced" : "R3 setup clocks", c_setup, es);
            chk(c_strobe == em, (wm_list[wi] == 0) ? "R6 strobe forced" : "R4 strobe clocks", c_strobe, em);
            chk(c_hold == eh, (wm_list[wi] == 0) ? "R6 hold forced" : "R5 hold clocks", c_hold, eh);
            chk(c_done == 1, "R5 completion clock", c_done, 1);
            chk(c_setup + c_strobe + c_hold + c_done == es + em + eh + 1, "R2 busy length",
                c_setup + c_strobe + c_hold + c_done, es + em + eh + 1);
            chk(c_irq == ((iq == 2'b01) ? 1 : 0), "R11 irq count", c_irq, (iq == 2'b01) ? 1 : 0);
            chk(c_badpin == 0, "R7 R8 pin pattern", c_badpin, 0);
            chk(c_badaddr == 0, "R10 bus address/cs", c_badaddr, 0);
            if (rd != 0) chk(data_q == exp_rd, "R8 read capture", int'(data_q), int'(exp_rd));
            else         chk(data_q == wv, "R8 write data kept", int'(data_q), int'(wv));
            exp_addr = exp_step(exp_addr, stp, cs);
            chk(addr_q == exp_addr, "R9 address step", int'(addr_q), int'(exp_addr));
            idx++;
        end

        // R10 carry into bit 14, borrow out of it, and wrap with chip select on
        wr_cfg(mk_cfg(0, 2'b00, 2'b01, 2'b00, 4'd1, 2'b00, 2'b10));
        wr_addr(16'h07FC);
        run_cycle(1'b0, 8'h11, 2'b10, 1'b0, 1'b0);
        chk(addr_q == 16'h4000, "R10 carry into a14", int'(addr_q), 16'h4000);
        wr_cfg(mk_cfg(0, 2'b00, 2'b10, 2'b00, 4'd1, 2'b00, 2'b10));
        run_cycle(1'b0, 8'h12, 2'b10, 1'b0, 1'b0);
        chk(addr_q == 16'h07FC, "R10 borrow from a14", int'(addr_q), 16'h07FC);
        wr_cfg(mk_cfg(1, 2'b00, 2'b01, 2'b00, 4'd1, 2'b00, 2'b11));
        wr_addr(16'h47FF);
        run_cycle(1'b1, 8'h13, 2'b11, 1'b1, 1'b0);
        chk(addr_q == 16'h4003, "R10 cs-on wrap keeps a14", int'(addr_q), 16'h4003);
        wr_cfg(mk_cfg(0, 2'b00, 2'b11, 2'b00, 4'd1, 2'b00, 2'b10));
        run_cycle(1'b0, 8'h14, 2'b10, 1'b0, 1'b0);
        chk(addr_q == 16'h4003, "R9 step code 11 no change", int'(addr_q), 16'h4003);

        // R12 starts and register writes during busy are ignored
        wr_cfg(mk_cfg(0, 2'b01, 2'b01, 2'b01, 4'd2, 2'b01, 2'b10));
        wr_addr(16'h0100);
        run_cycle(1'b0, 8'hA5, 2'b10, 1'b0, 1'b1);
        chk(data_q == 8'hA5, "R12 data write ignored while busy", int'(data_q), 8'hA5);
        chk(addr_q == 16'h0104, "R12 address write ignored while busy", int'(addr_q), 16'h0104);
        repeat (3) begin
            @(negedge clk);
            chk(busy == 0, "R12 no queued start", int'(busy), 0);
        end
        run_cycle(1'b1, 8'h00, 2'b10, 1'b0, 1'b0);
        chk(c_setup == 2 && c_strobe == 2 && c_hold == 1, "R12 config kept after poke",
            c_setup * 100 + c_strobe * 10 + c_hold, 221);
        chk(c_irq == 1, "R12 irq mode kept after poke", c_irq, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule